// File: doc/BRIEF.md
# Stereo Audio De-emphasis Filter

This block removes the treble lift that an emphasis stage added before transmission or storage. It works on an interleaved stream of signed 24-bit stereo samples. Each sample arrives with a one-cycle valid strobe and a tag that says which channel it belongs to. The filter is a first-order shelving section, derived by the bilinear transform from a zero at 15 µs and a pole at 50 µs. Its gain is unity at low frequencies. At a 44.1 kHz rate it begins to fall near 3.2 kHz and flattens out about 10 dB lower above roughly 10.6 kHz.

A shelf from fixed time constants lands at a different place in normalised frequency at each sample rate, so the block holds one fixed-point coefficient set per rate. A 2-bit mode input selects 32 kHz, 44.1 kHz, 48 kHz or no filtering. A 2-bit speed code tells the block whether the converter runs at single speed. Any other speed code forces samples through unchanged.

The left and right channels keep separate history. A change of mode or speed wipes both histories, so a stale state never leaks into a new filter setting. Every accepted sample produces exactly one output sample, two cycles later.

Top module: `deemph_filter`

## Requirements
- R1: While rst_n is low, and on the first cycle after release, out_valid is 0.
- R2: Each sample taken with in_valid high at a rising edge appears with out_valid high exactly two cycles later, with out_tag equal to its in_tag. No output appears without an input. Samples may arrive on every clock.
- R3: Mode encoding is 00 = off, 01 = 44.1 kHz, 10 = 32 kHz, 11 = 48 kHz. With mode 00, out_data equals the input sample bit for bit.
- R4: When speed is not 00 (00 means single speed), out_data equals the input sample for every mode.
- R5: When active, y[n] = (b0*x[n] + b1*x[n-1] - a1*y[n-1]) / 2^22. The coefficients are: 44.1 kHz b0=1800992, b1=-250417, a1=-2643729; 32 kHz b0=1957342, b1=39946, a1=-2197016; 48 kHz b0=1764502, b1=-318188, a1=-2747990.
- R6: The division in R5 adds 2^21 and then shifts right arithmetically by 22, so it rounds to nearest with ties upward. The result is clipped to [-8388608, 8388607]. For example, a first sample of 3 gives 1, and -3 gives -1 at 44.1 kHz.
- R7: The channel tag (0 = left, 1 = right) picks which channel's x[n-1] and y[n-1] are used and updated. A sample on one channel never changes the other channel's history.
- R8: Take a sample whose {speed, mode} differs from that of the previous accepted sample (the value after reset counts as 0000). That sample is computed with zero history, and the other channel's history is also zeroed.
- R9: Sustained full-scale inputs of either sign never wrap. The output stays within one LSB of the matching full-scale value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_tag | input | 1 | Channel of the input sample (0 left, 1 right) |
| in_data | input | 24 | Signed input sample |
| mode | input | 2 | Filter selection (see R3) |
| speed | input | 2 | Speed code; 00 is single speed |
| out_valid | output | 1 | Output sample strobe |
| out_tag | output | 1 | Channel of the output sample |
| out_data | output | 24 | Signed filtered sample |

## Verification
A corrupted x[n-1] or y[n-1] register shows up on the very next output of that channel. Because of the feedback term, it then decays over the following tens of samples instead of vanishing. A history that leaks between channels, or one that is not wiped on a selection change, makes the first output after a channel switch or mode switch differ from the zero-history value. The reference model therefore compares every output cycle. It switches channels and selections often, so these errors surface within two cycles of the offending sample.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
   localparam int COEF_W    = 24;
   localparam int COEF_FRAC = 22;

   typedef logic signed [COEF_W-1:0] coef_t;

   typedef struct packed {
      coef_t b0;
      coef_t b1;
      coef_t a1;
   } coef_set_t;

   typedef enum logic [1:0] {
      DM_OFF  = 2'b00,
      DM_44K1 = 2'b01,
      DM_32K  = 2'b10,
      DM_48K  = 2'b11
   } dmode_e;

   // Bilinear transform of (1 + s*15us) / (1 + s*50us), Q2.22; b0 + b1 == 1 + a1
   localparam coef_t C44_B0 =  24'sd1800992;
   localparam coef_t C44_B1 = -24'sd250417;
   localparam coef_t C44_A1 = -24'sd2643729;
   localparam coef_t C32_B0 =  24'sd1957342;
   localparam coef_t C32_B1 =  24'sd39946;
   localparam coef_t C32_A1 = -24'sd2197016;
   localparam coef_t C48_B0 =  24'sd1764502;
   localparam coef_t C48_B1 = -24'sd318188;
   localparam coef_t C48_A1 = -24'sd2747990;
endpackage

// File: rtl/deemph_coef_sel.sv
module deemph_coef_sel
   import deemph_pkg::*;
(
   input  logic [1:0] mode,
   output coef_set_t  coefs
);
   always_comb begin
      unique case (dmode_e'(mode))
         DM_44K1: coefs = '{b0: C44_B0, b1: C44_B1, a1: C44_A1};
         DM_32K:  coefs = '{b0: C32_B0, b1: C32_B1, a1: C32_A1};
         DM_48K:  coefs = '{b0: C48_B0, b1: C48_B1, a1: C48_A1};
         default: coefs = '{b0: '0, b1: '0, a1: '0};
      endcase
   end
endmodule

// File: rtl/deemph_mac.sv
module deemph_mac #(
   parameter int DW   = 24,
   parameter int CW   = 24,
   parameter int FRAC = 22
) (
   input  logic signed [DW-1:0] x,
   input  logic signed [DW-1:0] x1,
   input  logic signed [DW-1:0] y1,
   input  logic signed [CW-1:0] b0,
   input  logic signed [CW-1:0] b1,
   input  logic signed [CW-1:0] a1,
   output logic signed [DW-1:0] y
);
   localparam int AW = DW + CW + 2;
   localparam int RW = AW - FRAC;
   localparam logic signed [AW-1:0] HALF = AW'(64'sd1 <<< (FRAC - 1));
   localparam logic signed [RW-1:0] MAXV = RW'((64'sd1 <<< (DW - 1)) - 64'sd1);
   localparam logic signed [RW-1:0] MINV = RW'(-(64'sd1 <<< (DW - 1)));

   logic signed [AW-1:0] p_fwd, p_old, p_fb, acc;
   logic signed [RW-1:0] q;

   always_comb begin
      p_fwd = AW'(x)  * AW'(b0);
      p_old = AW'(x1) * AW'(b1);
      p_fb  = AW'(y1) * AW'(a1);
      acc   = p_fwd + p_old - p_fb + HALF;
      q     = acc[AW-1:FRAC];
      if (q > MAXV)      y = MAXV[DW-1:0];
      else if (q < MINV) y = MINV[DW-1:0];
      else               y = q[DW-1:0];
   end
endmodule

// File: rtl/deemph_state.sv
module deemph_state #(
   parameter int DW  = 24,
   parameter int NCH = 2,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [CHW-1:0]       ch,
   input  logic signed [DW-1:0] wx,
   input  logic signed [DW-1:0] wy,
   output logic signed [DW-1:0] x1_q [NCH],
   output logic signed [DW-1:0] y1_q [NCH]
);
   for (genvar g = 0; g < NCH; g++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            x1_q[g] <= '0;
            y1_q[g] <= '0;
         end else if (wr && ch == CHW'(g)) begin
            x1_q[g] <= wx;
            y1_q[g] <= wy;
         end else if (clr) begin
            x1_q[g] <= '0;
            y1_q[g] <= '0;
         end
      end
   end
endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
   import deemph_pkg::*;
#(
   parameter int DW = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_tag,
   input  logic signed [DW-1:0] in_data,
   input  logic [1:0]           mode,
   input  logic [1:0]           speed,
   output logic                 out_valid,
   output logic                 out_tag,
   output logic signed [DW-1:0] out_data
);
   localparam int NCH = 2;

   if (DW < 16 || DW > 32) begin : g_bad_dw
      $error("deemph_filter: DW must lie in 16..32");
   end
   if (COEF_FRAC >= COEF_W) begin : g_bad_frac
      $error("deemph_filter: coefficient fraction exceeds width");
   end

   logic [3:0]           sel_now, sel_last;
   logic                 bypass, sel_chg;
   coef_set_t            cs;
   logic signed [DW-1:0] x1_q [NCH];
   logic signed [DW-1:0] y1_q [NCH];
   logic signed [DW-1:0] x1_use, y1_use, y_flt, y_pick;
   logic                 a_valid, a_tag;
   logic signed [DW-1:0] a_data;

   assign sel_now = {speed, mode};
   assign bypass  = (speed != 2'b00) || (dmode_e'(mode) == DM_OFF);
   assign sel_chg = in_valid && (sel_now != sel_last);
   assign x1_use  = sel_chg ? '0 : x1_q[in_tag];
   assign y1_use  = sel_chg ? '0 : y1_q[in_tag];
   assign y_pick  = bypass ? in_data : y_flt;

   always_ff @(posedge clk) begin
      if (!rst_n)        sel_last <= '0;
      else if (in_valid) sel_last <= sel_now;
   end

   deemph_coef_sel u_coef (
      .mode  (mode),
      .coefs (cs)
   );

   deemph_state #(.DW(DW), .NCH(NCH)) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sel_chg),
      .wr    (in_valid && !bypass),
      .ch    (in_tag),
      .wx    (in_data),
      .wy    (y_flt),
      .x1_q  (x1_q),
      .y1_q  (y1_q)
   );

   deemph_mac #(.DW(DW), .CW(COEF_W), .FRAC(COEF_FRAC)) u_mac (
      .x  (in_data),
      .x1 (x1_use),
      .y1 (y1_use),
      .b0 (cs.b0),
      .b1 (cs.b1),
      .a1 (cs.a1),
      .y  (y_flt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_valid   <= 1'b0;
         a_tag     <= 1'b0;
         a_data    <= '0;
         out_valid <= 1'b0;
         out_tag   <= 1'b0;
         out_data  <= '0;
      end else begin
         a_valid   <= in_valid;
         if (in_valid) begin
            a_tag  <= in_tag;
            a_data <= y_pick;
         end
         out_valid <= a_valid;
         if (a_valid) begin
            out_tag  <= a_tag;
            out_data <= a_data;
         end
      end
   end
endmodule

// File: rtl/deemph_filter_chk.sv
module deemph_filter_chk #(
   parameter int DW = 24
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_tag,
   input logic signed [DW-1:0] in_data,
   input logic [1:0]           mode,
   input logic [1:0]           speed,
   input logic                 out_valid,
   input logic                 out_tag,
   input logic signed [DW-1:0] out_data
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   assert_latency_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 (out_valid && out_tag == $past(in_tag, 2)));

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   assert_off_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b00) |=> ##1 (out_data == $past(in_data, 2)));

   assert_speed_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && speed != 2'b00) |=> ##1 (out_data == $past(in_data, 2)));
endmodule

bind deemph_filter deemph_filter_chk #(.DW(DW)) u_chk (.*);

// File: tb/deemph_filter_test.sv
module deemph_filter_test;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_tag = 1'b0;
   logic signed [23:0] in_data = '0;
   logic [1:0]         mode = 2'b00;
   logic [1:0]         speed = 2'b00;
   logic               out_valid, out_tag;
   logic signed [23:0] out_data;

   int    vectors = 0;
   int    fails = 0;
   int    cyc = 0;
   string cur_req = "R1";
   int unsigned seed = 32'h1234_5678;

   // reference model state
   longint hx [2];
   longint hy [2];
   int     last_sel = 0;
   bit     e1v = 0, e2v = 0;
   bit     e1t = 0, e2t = 0;
   longint e1d = 0, e2d = 0;

   always #10 clk = ~clk;

   deemph_filter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
      .in_data(in_data), .mode(mode), .speed(speed),
      .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
   );

   function automatic void coefs(input int m, output longint b0, output longint b1,
                                 output longint a1);
      case (m)
         1: begin b0 = 1800992; b1 = -250417; a1 = -2643729; end
         2: begin b0 = 1957342; b1 = 39946;   a1 = -2197016; end
         default: begin b0 = 1764502; b1 = -318188; a1 = -2747990; end
      endcase
   endfunction

   always @(posedge clk) begin
      longint x, y, b0, b1, a1, acc;
      int     sel, ch;
      e2v = e1v; e2t = e1t; e2d = e1d;
      if (!rst_n) begin
         hx[0] = 0; hx[1] = 0; hy[0] = 0; hy[1] = 0;
         last_sel = 0; e1v = 0; e2v = 0;
      end else begin
         e1v = in_valid;
         if (in_valid) begin
            x = longint'(in_data);
            ch = in_tag;
            sel = speed * 4 + mode;
            if (sel != last_sel) begin
               hx[0] = 0; hx[1] = 0; hy[0] = 0; hy[1] = 0;
            end
            last_sel = sel;
            if (speed != 0 || mode == 0) begin
               y = x;
            end else begin
               coefs(mode, b0, b1, a1);
               acc = b0 * x + b1 * hx[ch] - a1 * hy[ch] + 2097152;
               y = acc >>> 22;
               if (y > 8388607) y = 8388607;
               if (y < -8388608) y = -8388608;
               hx[ch] = x; hy[ch] = y;
            end
            e1t = in_tag; e1d = y;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (out_valid !== e2v) begin
            fails++;
            $display("FAIL %s out_valid act=%0b exp=%0b", cur_req, out_valid, e2v);
         end else if (e2v && (out_tag !== e2t || longint'(out_data) != e2d)) begin
            fails++;
            $display("FAIL %s tag/data act=%0b/%0d exp=%0b/%0d", cur_req,
                     out_tag, out_data, e2t, e2d);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic send(input bit t, input longint v);
      @(negedge clk);
      in_valid = 1'b1; in_tag = t; in_data = 24'(v);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   function automatic longint rnd24();
      seed = seed * 1103515245 + 12345;
      return longint'($signed(seed[30:7]));
   endfunction

   task automatic burst(input int n, input bit gaps);
      for (int i = 0; i < n; i++) begin
         send(i[0], rnd24());
         if (gaps && (i % 5 == 4)) idle(2);
      end
      idle(3);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);

      // R3: filter off passes samples unchanged
      cur_req = "R3";
      send(0, 100); send(1, -200); send(0, 8388607); send(1, -8388608);
      idle(3);

      // R5 / R7: each coefficient set, interleaved channels, with and without gaps
      cur_req = "R5";
      mode = 2'b01; burst(40, 1'b0);
      mode = 2'b10; burst(40, 1'b1);
      mode = 2'b11; burst(40, 1'b0);
      cur_req = "R7";
      for (int i = 0; i < 12; i++) send(0, 2000000);
      send(1, -1000); send(1, -1000); send(0, 2000000);
      idle(3);

      // R6: rounding on a cleared history at 44.1 kHz
      cur_req = "R6";
      mode = 2'b01;
      send(0, 3); send(1, -3);
      @(negedge clk); in_valid = 1'b0;
      chk(out_valid && out_tag == 1'b0 && out_data == 24'sd1, "R6", longint'(out_data), 1);
      @(negedge clk);
      chk(out_valid && out_tag == 1'b1 && out_data == -24'sd1, "R6", longint'(out_data), -1);
      idle(2);

      // R2: latency and tag on a lone sample
      cur_req = "R2";
      send(1, 12345);
      @(negedge clk); in_valid = 1'b0;
      chk(out_valid == 1'b0, "R2", longint'(out_valid), 0);
      @(negedge clk);
      chk(out_valid == 1'b1 && out_tag == 1'b1, "R2", longint'(out_tag), 1);
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", longint'(out_valid), 0);

      // R8: selection changes in mid stream clear both histories
      cur_req = "R8";
      mode = 2'b10; for (int i = 0; i < 6; i++) send(i[0], 4000000);
      mode = 2'b11; for (int i = 0; i < 6; i++) send(i[0], -4000000);
      speed = 2'b01; send(0, 55); speed = 2'b00; send(1, 4000000); send(0, 4000000);
      idle(3);

      // R4: non-single-speed codes bypass every mode
      cur_req = "R4";
      for (int s = 1; s < 4; s++) begin
         for (int m = 0; m < 4; m++) begin
            speed = 2'(s); mode = 2'(m);
            send(0, rnd24()); send(1, rnd24());
         end
      end
      speed = 2'b00;
      idle(3);

      // R9: sustained full scale of each sign
      cur_req = "R9";
      mode = 2'b11;
      for (int i = 0; i < 160; i++) send(i[0], i[0] ? -8388608 : 8388607);
      @(negedge clk); in_valid = 1'b0;
      chk(out_tag == 1'b0 && longint'(out_data) >= 8388606, "R9", longint'(out_data), 8388607);
      @(negedge clk);
      chk(out_tag == 1'b1 && longint'(out_data) <= -8388607, "R9", longint'(out_data), -8388608);
      idle(3);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule